// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of transfer commands by itself. Software loads up to sixteen command entries, each with an 8-bit transmit byte and a 4-bit peripheral-select code. It then sets the index of the last entry to run, sets the clock, phase and inter-entry spacing, and pulses `start`. The controller then shifts every entry from 0 to the last index, MSB first. It drives the entry's select code on `pcs` and holds the frame signal `ss_n` low while that entry is on the wire. Each received byte is stored in a receive array at the same index as the command that produced it.

Completion is reported once for the whole queue, not once per byte. A sticky `done` flag rises at the end of the last entry, and `irq` mirrors it when `irq_en` is set. Software clears `done` by pulsing `done_clr`, which is the write-one-to-clear action, and that also drops `irq`. The configuration inputs are captured when a run starts. The queue cannot be rewritten while a run is in progress. A board-level decoder is expected to turn `pcs` into individual chip selects.

Top module: `qspi_master`

## Requirements
- R1: After reset, `busy`, `done` and `irq` are 0, `ss_n` is 1 and `sck` is 0 (with `cfg_cpol` at 0).
- R2: A `start` pulse while idle runs entries 0 through `cfg_last` in ascending order. Each entry is one frame with `ss_n` low and 8 bits on `mosi`, most significant bit first. No extra frames are produced.
- R3: During every frame, `pcs` equals the select code stored in that entry and does not change while `ss_n` is low.
- R4: The byte received in a frame is stored at the entry's own index. It is read through `rx_addr` and appears on `rx_data` one clock after the address is presented.
- R5: `sck` rests at `cfg_cpol` outside frames. With `cfg_cpha`=0, `miso` is sampled on the first (leading) edge of each bit and `mosi` changes on the trailing edge. With `cfg_cpha`=1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R6: Each `sck` half-period lasts H system clocks, where H is `cfg_half`, or 2 if `cfg_half` is below 2. Each frame keeps `ss_n` low for exactly 16·H+1 clocks.
- R7: Between two entries of one run, `ss_n` stays high for exactly `cfg_gap`+3 clocks.
- R8: `busy` is 1 from the clock after an accepted `start` until the clock in which `done` rises. A `start` pulse while `busy` is 1 has no effect.
- R9: Queue writes (`q_we`) while `busy` is 1 are ignored, and the stored entry keeps its earlier contents.
- R10: `done` rises once, at the end of the last entry, and stays set until a `done_clr` pulse. `irq` is `done` qualified by `irq_en`, updated one clock later, and `done_clr` drops both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| q_we | input | 1 | Write strobe for a command entry (ignored while busy) |
| q_addr | input | 4 | Command entry index |
| q_data | input | 8 | Transmit byte of the entry |
| q_sel | input | 4 | Peripheral-select code of the entry |
| rx_addr | input | 4 | Receive array read index |
| rx_data | output | 8 | Received byte at `rx_addr`, one clock latency |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_half | input | 8 | SCK half-period in system clocks (minimum 2) |
| cfg_gap | input | 8 | Extra idle clocks between entries |
| cfg_last | input | 4 | Index of the final entry of the run |
| irq_en | input | 1 | Interrupt enable for the done flag |
| start | input | 1 | Start pulse |
| done_clr | input | 1 | Clear pulse for the done flag |
| busy | output | 1 | Queue run in progress |
| done | output | 1 | Sticky queue-complete flag |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low frame signal |
| pcs | output | 4 | Encoded peripheral select |

## Verification
A wrong entry index or a read pointer that advances early shows up within the next frame. The serial byte and the `pcs` code then belong to a neighbouring entry, and the stored receive byte lands in the wrong slot. A fault in the phase or edge counter corrupts the captured byte and stretches the `ss_n` low time away from 16·H+1 within that same frame. A fault in the gap counter shows in the first `ss_n` high interval of the run. A fault in the last-entry compare or the done logic shows as a wrong frame count or as a `done`/`busy` mismatch when the run ends.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_LOAD,
    ST_SHIFT,
    ST_WR,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/qspi_ram.sv
// Simple dual-port array, registered read, suitable for block RAM inference.
module qspi_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qspi_shifter.sv
// Bit engine: one frame of DATA_W bits, 2*DATA_W sck edges.
module qspi_shifter #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              idle_pol,
  input  logic [DIV_W-1:0]  half,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              last_edge
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic              active;
  logic [DIV_W-1:0]  hc;
  logic [EW-1:0]     ecnt;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              tick;
  logic              leading;
  logic              sample;

  assign tick      = active && (hc == half - 1'b1);
  assign leading   = (sck == cpol);
  assign sample    = leading ^ cpha;
  assign last_edge = tick && (ecnt == EW'(EDGES - 1));
  assign rx_data   = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hc     <= '0;
      ecnt   <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (load) begin
      active <= 1'b1;
      hc     <= '0;
      ecnt   <= '0;
      sck    <= cpol;
      if (cpha) begin
        tx_sr <= tx_data;
      end else begin
        mosi  <= tx_data[DATA_W-1];
        tx_sr <= {tx_data[DATA_W-2:0], 1'b0};
      end
    end else if (active) begin
      if (tick) begin
        hc   <= '0;
        sck  <= ~sck;
        ecnt <= ecnt + 1'b1;
        if (last_edge) active <= 1'b0;
        if (sample) begin
          rx_sr <= {rx_sr[DATA_W-2:0], miso};
        end else begin
          mosi  <= tx_sr[DATA_W-1];
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end else begin
      sck <= idle_pol;
    end
  end
endmodule

// File: rtl/qspi_seq.sv
// Queue sequencer: walks entries, frames them, writes results, flags completion.
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int AW    = 4,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             done_clr,
  input  logic             irq_en,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic [AW-1:0]    cfg_last,
  input  logic             last_edge,
  input  logic [SEL_W-1:0] cmd_sel,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             ss_n,
  output logic [SEL_W-1:0] pcs,
  output logic [AW-1:0]    idx,
  output logic             sh_load,
  output logic             rx_we,
  output logic             cpol_l,
  output logic             cpha_l,
  output logic [DIV_W-1:0] half_l,
  output logic             sck_idle
);
  seq_state_t       state;
  logic [GAP_W-1:0] gap_l;
  logic [GAP_W-1:0] gcnt;
  logic [AW-1:0]    last_l;
  logic             fin;
  logic             done_n;

  assign sh_load  = (state == ST_LOAD);
  assign rx_we    = (state == ST_WR);
  assign fin      = rx_we && (idx == last_l);
  assign done_n   = fin | (done & ~done_clr);
  assign sck_idle = busy ? cpol_l : cfg_cpol;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      irq    <= 1'b0;
      ss_n   <= 1'b1;
      pcs    <= '0;
      idx    <= '0;
      gcnt   <= '0;
      gap_l  <= '0;
      last_l <= '0;
      cpol_l <= 1'b0;
      cpha_l <= 1'b0;
      half_l <= DIV_W'(2);
    end else begin
      done <= done_n;
      irq  <= done_n & irq_en;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            cpol_l <= cfg_cpol;
            cpha_l <= cfg_cpha;
            half_l <= (cfg_half < DIV_W'(2)) ? DIV_W'(2) : cfg_half;
            gap_l  <= cfg_gap;
            last_l <= cfg_last;
            state  <= ST_RD;
          end
        end
        ST_RD: state <= ST_LOAD;
        ST_LOAD: begin
          ss_n  <= 1'b0;
          pcs   <= cmd_sel;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (last_edge) state <= ST_WR;
        end
        ST_WR: begin
          ss_n <= 1'b1;
          if (fin) begin
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            gcnt  <= gap_l;
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gcnt == '0) begin
            idx   <= idx + 1'b1;
            state <= ST_RD;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_master.sv
module qspi_master #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     q_we,
  input  logic [$clog2(DEPTH)-1:0] q_addr,
  input  logic [DATA_W-1:0]        q_data,
  input  logic [SEL_W-1:0]         q_sel,
  input  logic [$clog2(DEPTH)-1:0] rx_addr,
  output logic [DATA_W-1:0]        rx_data,
  input  logic                     cfg_cpol,
  input  logic                     cfg_cpha,
  input  logic [DIV_W-1:0]         cfg_half,
  input  logic [GAP_W-1:0]         cfg_gap,
  input  logic [$clog2(DEPTH)-1:0] cfg_last,
  input  logic                     irq_en,
  input  logic                     start,
  input  logic                     done_clr,
  output logic                     busy,
  output logic                     done,
  output logic                     irq,
  output logic                     sck,
  output logic                     mosi,
  input  logic                     miso,
  output logic                     ss_n,
  output logic [SEL_W-1:0]         pcs
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CMD_W = DATA_W + SEL_W;

  logic [CMD_W-1:0]  cmd_rdata;
  logic [AW-1:0]     idx;
  logic              sh_load;
  logic              rx_we;
  logic              cpol_l;
  logic              cpha_l;
  logic [DIV_W-1:0]  half_l;
  logic              sck_idle;
  logic              last_edge;
  logic [DATA_W-1:0] sh_rx;

  qspi_ram #(.W(CMD_W), .DEPTH(DEPTH), .AW(AW)) cmd_ram_i (
    .clk   (clk),
    .we    (q_we & ~busy),
    .waddr (q_addr),
    .wdata ({q_sel, q_data}),
    .raddr (idx),
    .rdata (cmd_rdata)
  );

  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) rx_ram_i (
    .clk   (clk),
    .we    (rx_we),
    .waddr (idx),
    .wdata (sh_rx),
    .raddr (rx_addr),
    .rdata (rx_data)
  );

  qspi_seq #(.SEL_W(SEL_W), .AW(AW), .DIV_W(DIV_W), .GAP_W(GAP_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done_clr  (done_clr),
    .irq_en    (irq_en),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .cfg_half  (cfg_half),
    .cfg_gap   (cfg_gap),
    .cfg_last  (cfg_last),
    .last_edge (last_edge),
    .cmd_sel   (cmd_rdata[CMD_W-1:DATA_W]),
    .busy      (busy),
    .done      (done),
    .irq       (irq),
    .ss_n      (ss_n),
    .pcs       (pcs),
    .idx       (idx),
    .sh_load   (sh_load),
    .rx_we     (rx_we),
    .cpol_l    (cpol_l),
    .cpha_l    (cpha_l),
    .half_l    (half_l),
    .sck_idle  (sck_idle)
  );

  qspi_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) shifter_i (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .cpol      (cpol_l),
    .cpha      (cpha_l),
    .idle_pol  (sck_idle),
    .half      (half_l),
    .tx_data   (cmd_rdata[DATA_W-1:0]),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .rx_data   (sh_rx),
    .last_edge (last_edge)
  );
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             irq,
  input logic             ss_n,
  input logic             sck,
  input logic [SEL_W-1:0] pcs
);
  // R3: select code frozen for the whole frame
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ss_n && $past(!ss_n)) |-> $stable(pcs));

  // R8: frames only occur inside a run
  p_frame_in_run_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ss_n);

  // R8: an accepted start raises busy on the next clock
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R10: done rises exactly when the run ends
  p_done_ends_run_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  // R10: no interrupt without the done flag
  p_irq_needs_done_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> !irq);

  // R5: sck rests between entries of a run
  p_sck_quiet_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && ss_n && $past(busy && ss_n)) |-> $stable(sck));
endmodule

bind qspi_master qspi_master_chk #(.SEL_W(SEL_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .irq   (irq),
  .ss_n  (ss_n),
  .sck   (sck),
  .pcs   (pcs)
);

// File: tb/qspi_master_tb_top.sv
`timescale 1ns/1ps
module qspi_master_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       q_we = 1'b0;
  logic [3:0] q_addr = '0;
  logic [7:0] q_data = '0;
  logic [3:0] q_sel = '0;
  logic [3:0] rx_addr = '0;
  logic [7:0] rx_data;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] cfg_half = 8'd2, cfg_gap = '0;
  logic [3:0] cfg_last = '0;
  logic       irq_en = 1'b0, start = 1'b0, done_clr = 1'b0;
  logic       busy, done, irq, sck, mosi, ss_n;
  logic       miso = 1'b0;
  logic [3:0] pcs;

  always #5 clk = ~clk;

  qspi_master dut_i (
    .clk(clk), .rst(rst), .q_we(q_we), .q_addr(q_addr), .q_data(q_data), .q_sel(q_sel),
    .rx_addr(rx_addr), .rx_data(rx_data), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_half(cfg_half), .cfg_gap(cfg_gap), .cfg_last(cfg_last), .irq_en(irq_en),
    .start(start), .done_clr(done_clr), .busy(busy), .done(done), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .pcs(pcs)
  );

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] qd(input int i); return 8'((i * 29 + 7)); endfunction
  function automatic logic [3:0] qs(input int i); return 4'((i * 7 + 3)); endfunction
  function automatic logic [7:0] resp(input int n); return 8'((n * 37 + 91)); endfunction

  // Slave model
  bit         b_cpol = 1'b0, b_cpha = 1'b0;
  int         sl_n = 0;
  logic [7:0] sl_tx = '0, sl_rx = '0;
  logic [7:0] sl_rec [512];
  logic [3:0] sl_pcs [512];
  bit         sl_lead;

  always @(negedge ss_n) begin
    sl_tx = resp(sl_n);
    sl_rx = '0;
    if (!b_cpha) miso = sl_tx[7];
  end

  always @(sck) begin
    if (ss_n === 1'b0) begin
      sl_lead = (sck !== b_cpol);
      if (sl_lead ^ b_cpha) begin
        sl_rx = {sl_rx[6:0], mosi};
      end else if (b_cpha) begin
        miso  = sl_tx[7];
        sl_tx = sl_tx << 1;
      end else begin
        sl_tx = sl_tx << 1;
        miso  = sl_tx[7];
      end
    end
  end

  always @(posedge ss_n) begin
    if (!rst) begin
      sl_rec[sl_n % 512] = sl_rx;
      sl_pcs[sl_n % 512] = pcs;
      sl_n++;
    end
  end

  // Frame timing monitor
  int  exp_low = 0, exp_gap = 0, low_bad = 0, gap_bad = 0, last_low = 0, last_gap = 0;
  int  run_len = 0;
  bit  prev_ss = 1'b1, hi_busy = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ss_n !== prev_ss) begin
        if (prev_ss == 1'b0) begin
          last_low = run_len;
          if (run_len != exp_low) low_bad++;
          hi_busy = busy;
        end else if (hi_busy) begin
          last_gap = run_len;
          if (run_len != exp_gap) gap_bad++;
        end
        run_len = 1;
        prev_ss = ss_n;
      end else begin
        run_len++;
      end
    end
  end

  int n0 = 0;

  task automatic write_entry(input int i, input logic [7:0] d, input logic [3:0] s);
    @(negedge clk);
    q_we = 1'b1; q_addr = 4'(i); q_data = d; q_sel = s;
    @(negedge clk);
    q_we = 1'b0;
  endtask

  task automatic read_rx(input int i, output logic [7:0] v);
    @(negedge clk);
    rx_addr = 4'(i);
    @(negedge clk);
    v = rx_data;
  endtask

  task automatic clear_done();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
  endtask

  task automatic begin_run(input int last, input bit pol, input bit pha,
                           input int half, input int gap, input bit ien);
    int hh;
    hh = (half < 2) ? 2 : half;
    b_cpol = pol; b_cpha = pha;
    exp_low = 16 * hh + 1; exp_gap = gap + 3; low_bad = 0; gap_bad = 0;
    @(negedge clk);
    cfg_last = 4'(last); cfg_cpol = pol; cfg_cpha = pha;
    cfg_half = 8'(half); cfg_gap = 8'(gap); irq_en = ien;
    n0 = sl_n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic verify_run(input int last, input bit pol);
    logic [7:0] v;
    chk(sl_n - n0 == last + 1, "R2 frame count", sl_n - n0, last + 1);
    for (int i = 0; i <= last; i++) begin
      chk(sl_rec[(n0 + i) % 512] == qd(i), "R2 mosi byte", sl_rec[(n0 + i) % 512], qd(i));
      chk(sl_pcs[(n0 + i) % 512] == qs(i), "R3 select code", sl_pcs[(n0 + i) % 512], qs(i));
      read_rx(i, v);
      chk(v == resp(n0 + i), "R4 R5 stored rx byte", v, resp(n0 + i));
    end
    chk(low_bad == 0, "R6 frame length", last_low, exp_low);
    chk(gap_bad == 0, "R7 gap length", last_gap, exp_gap);
    chk(sck == pol, "R5 sck idle level", sck, pol);
    chk(done == 1'b1, "R10 done set", done, 1);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(ss_n == 1, "R1 ss_n", ss_n, 1);
    chk(sck == 0, "R1 sck", sck, 0);

    for (int i = 0; i < 16; i++) write_entry(i, qd(i), qs(i));

    // Mode and divider sweep; half of 0 must behave as 2
    for (int t = 0; t < 8; t++) begin
      clear_done();
      begin_run(3, t[0], t[1], t[2] ? 3 : 0, t, 1'b0);
      wait_idle();
      verify_run(3, t[0]);
      chk(irq == 0, "R10 irq masked", irq, 0);
    end

    // R10: enable after completion raises irq one clock later, clear drops both
    @(negedge clk);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1, "R10 irq follows enable", irq, 1);
    clear_done();
    chk(done == 0, "R10 done cleared", done, 0);
    chk(irq == 0, "R10 irq cleared", irq, 0);

    // Full queue run with irq enabled
    begin_run(15, 1'b0, 1'b0, 2, 0, 1'b1);
    wait_idle();
    verify_run(15, 1'b0);
    @(negedge clk);
    chk(irq == 1, "R10 irq at completion", irq, 1);
    chk(done == 1, "R10 done held", done, 1);
    clear_done();
    chk(irq == 0, "R10 irq dropped", irq, 0);

    // R8 start while busy, R9 write while busy
    begin_run(3, 1'b1, 1'b0, 2, 1, 1'b0);
    repeat (5) @(negedge clk);
    write_entry(0, 8'hA5, 4'hF);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    verify_run(3, 1'b1);
    repeat (4) @(negedge clk);
    chk(busy == 0, "R8 no restart", busy, 0);
    chk(sl_n - n0 == 4, "R8 extra start ignored", sl_n - n0, 4);
    clear_done();
    begin_run(0, 1'b0, 1'b1, 4, 0, 1'b0);
    wait_idle();
    chk(sl_rec[n0 % 512] == qd(0), "R9 entry unchanged data", sl_rec[n0 % 512], qd(0));
    chk(sl_pcs[n0 % 512] == qs(0), "R9 entry unchanged select", sl_pcs[n0 % 512], qs(0));
    read_rx(0, v);
    chk(v == resp(n0), "R4 single entry rx", v, resp(n0));
    chk(low_bad == 0, "R6 frame length H4", last_low, exp_low);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule